// File: doc/BRIEF.md
# Interrupt to MSI Message Dispatcher

This block turns a request to service one interrupt pin into a message-signalled interrupt. It accepts a pin index and fetches that pin's 64-bit redirection entry from an external configuration table through a read port. A masked entry ends the request at that point. For an unmasked entry the block builds a 32-bit message address and a 32-bit message data word from the entry's fields and offers them on a valid/ready channel. It then waits for a one-bit accept/reject response from the receiver.

The block owns two status bits per pin. The delivery-status bit shows that a message is pending. The remote-IRR bit shows that a level-triggered interrupt has been delivered and is waiting for its end-of-interrupt. An end-of-interrupt input carries a vector and releases every level-triggered pin configured with that vector. To do this, the table exposes every pin's vector and trigger-mode bit as flat wires. Only one request is in flight at a time, and a busy output holds off new requests until the response arrives.

Entry layout used by the block: vector in bits 7:0, delivery mode in 10:8, destination mode in 11 (0 physical, 1 logical), trigger mode in 15 (0 edge, 1 level), mask in 16, destination in 63:56. Bits 12 and 14 of the table entry are ignored, because the block keeps those status bits itself.

Top module: `irq_msi_dispatch`

## Requirements
- R1: When the fetched entry has mask bit 16 set, the request ends with no message presented (msg_valid stays 0), and neither the remote-IRR nor the delivery-status bits change.
- R2: The destination ID placed in address bits 19:12 is {4'b0, entry[59:56]} in physical mode (entry bit 11 = 0) and entry[63:56] in logical mode (entry bit 11 = 1). In physical mode, address bits 19:16 are therefore 0.
- R3: The message address is 0xFEE00000 | (destination ID << 12) | (1 << 3) | (entry bit 11 << 2).
- R4: The message data is (entry bit 15 << 15) | (remote IRR << 14) | (entry[10:8] << 8) | entry[7:0]. The remote IRR used is the value held before this delivery updates it.
- R5: Every 3-bit delivery mode code, 0 through 7, is passed unchanged into data bits 10:8.
- R6: On an accepted response, the pin's delivery-status bit clears. Its remote-IRR bit is set when the entry is level-triggered and left unchanged when it is edge-triggered.
- R7: On a rejected response, the pin's remote-IRR and delivery-status bits are unchanged.
- R8: An end-of-interrupt with vector V clears remote IRR on every pin whose configured vector equals V and whose trigger bit is 1 (level). Pins with trigger bit 0 keep their remote IRR, and so do pins with another vector.
- R9: When an acceptance that sets a pin's remote IRR and an end-of-interrupt that would clear it fall in the same cycle, the bit ends up set.
- R10: svc_busy is 1 from the cycle after a request is captured until the cycle after the response or the mask drop. Requests seen while busy are ignored.
- R11: A request whose pin index is NUM_PINS (24) or more is ignored: svc_busy stays 0 and no message appears.
- R12: While msg_valid is 1 and msg_ready is 0, msg_valid, msg_addr and msg_data hold steady.
- R13: The delivery-status bit of a pin is set when its message is first presented. After reset, all status bits, msg_valid and svc_busy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| svc_valid | input | 1 | Service request strobe |
| svc_pin | input | IDX_W (5) | Pin index to service |
| svc_busy | output | 1 | A request is in flight; new requests are ignored |
| tbl_rd_idx | output | IDX_W (5) | Table read index |
| tbl_rd_data | input | 64 | Redirection entry at tbl_rd_idx, same cycle |
| cfg_vec_flat | input | NUM_PINS*8 (192) | Vector of every pin, pin i in bits 8i+7:8i |
| cfg_lvl | input | NUM_PINS (24) | Trigger bit of every pin (1 = level) |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_addr | output | 32 | Message address (upper address word is zero) |
| msg_data | output | 32 | Message data |
| rsp_valid | input | 1 | Receiver response strobe |
| rsp_accept | input | 1 | 1 = accepted, 0 = rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | End-of-interrupt vector |
| remote_irr_o | output | NUM_PINS (24) | Remote-IRR bit per pin |
| dlv_status_o | output | NUM_PINS (24) | Delivery-status bit per pin |

## Verification
The assertions check these rules on every cycle:
- an offered message holds steady under back-pressure;
- physical-mode addresses never carry upper destination bits;
- status bits move only under an acceptance, a presentation or an end-of-interrupt;
- an acceptance on a level pin always leaves remote IRR set, even against a simultaneous end-of-interrupt;
- a matching end-of-interrupt clears a level pin and leaves an edge pin alone.

Only the bench scenarios can show the full address and data encodings for both destination modes and all eight delivery modes. The same holds for the pre-update remote-IRR bit in a repeated delivery, the mask drop, the rejection path, and the ignoring of out-of-range and back-pressured requests.

// File: rtl/irq_msi_pkg.sv
// Package: shared field positions, constants and the controller state type
// for the interrupt-to-MSI dispatcher.
// Assumes a 64-bit redirection entry with the layout listed in the brief.
package irq_msi_pkg;

    localparam int ENTRY_W   = 64;
    localparam int VEC_W     = 8;
    localparam int DMODE_W   = 3;
    localparam int MSG_W     = 32;

    // Entry field positions (decoded by this block)
    localparam int F_VEC_LO   = 0;
    localparam int F_DMODE_LO = 8;
    localparam int F_DSTMODE  = 11;
    localparam int F_TRIG     = 15;
    localparam int F_MASK     = 16;
    localparam int F_DEST_LO  = 56;

    // Fixed message address parts
    localparam logic [11:0] MSG_BASE_HI = 12'hFEE;
    localparam logic        REDIR_HINT  = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_SEND   = 2'd2,
        ST_WAIT   = 2'd3
    } disp_state_t;

    // Destination ID: 4 bits in physical mode, 8 bits in logical mode
    function automatic logic [7:0] dest_id(input logic [ENTRY_W-1:0] ent);
        logic [7:0] raw;
        raw = ent[F_DEST_LO +: 8];
        return ent[F_DSTMODE] ? raw : {4'b0000, raw[3:0]};
    endfunction

endpackage

// File: rtl/msi_compose.sv
// Module: msi_compose
// Builds the message address and data words from one redirection entry
// and reports the entry's mask and trigger bits.
// Assumes: purely combinational; remote_bit is the pin's remote IRR before
// any update caused by the delivery being built.
module msi_compose
    import irq_msi_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               remote_bit,
    output logic [MSG_W-1:0]   addr,
    output logic [MSG_W-1:0]   data,
    output logic               masked,
    output logic               level
);

    logic [7:0]         did;
    logic [VEC_W-1:0]   vec;
    logic [DMODE_W-1:0] dmode;
    logic               dstmode;
    logic               unused_fields;

    // Field extraction
    always_comb begin
        did     = dest_id(entry);
        vec     = entry[F_VEC_LO +: VEC_W];
        dmode   = entry[F_DMODE_LO +: DMODE_W];
        dstmode = entry[F_DSTMODE];
        masked  = entry[F_MASK];
        level   = entry[F_TRIG];
    end

    assign unused_fields = ^{entry[55:17], entry[14:12]};

    // Address word assembly
    always_comb begin
        addr        = '0;
        addr[31:20] = MSG_BASE_HI;
        addr[19:12] = did;
        addr[3]     = REDIR_HINT;
        addr[2]     = dstmode;
    end

    // Data word assembly
    always_comb begin
        data        = '0;
        data[15]    = level;
        data[14]    = remote_bit;
        data[10:8]  = dmode;
        data[7:0]   = vec;
    end

endmodule

// File: rtl/pin_status_bank.sv
// Module: pin_status_bank
// Holds the remote-IRR and delivery-status bits of every pin.
// Assumes: set_pend and acc never pulse in the same cycle (single request
// in flight). An acceptance that sets remote IRR overrides a same-cycle
// end-of-interrupt clear.
module pin_status_bank
    import irq_msi_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_pend,
    input  logic                      acc,
    input  logic                      acc_lvl,
    input  logic [IDX_W-1:0]          upd_pin,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vec,
    input  logic [NUM_PINS*VEC_W-1:0] cfg_vec_flat,
    input  logic [NUM_PINS-1:0]       cfg_lvl,
    output logic [NUM_PINS-1:0]       remote_irr,
    output logic [NUM_PINS-1:0]       dlv_status
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
            logic hit;
            logic eoi_hit;
            assign hit     = (int'(upd_pin) == gi);
            assign eoi_hit = eoi_valid && cfg_lvl[gi] &&
                             (cfg_vec_flat[gi*VEC_W +: VEC_W] == eoi_vec);

            // Delivery status: set when presented, cleared on acceptance
            always_ff @(posedge clk) begin
                if (!rst_n)              dlv_status[gi] <= 1'b0;
                else if (set_pend && hit) dlv_status[gi] <= 1'b1;
                else if (acc && hit)      dlv_status[gi] <= 1'b0;
            end

            // Remote IRR: set on level acceptance (wins), cleared by matching EOI
            always_ff @(posedge clk) begin
                if (!rst_n)                      remote_irr[gi] <= 1'b0;
                else if (acc && acc_lvl && hit)  remote_irr[gi] <= 1'b1;
                else if (eoi_hit)                remote_irr[gi] <= 1'b0;
            end

            // R8: a matching EOI with no competing set clears a level pin
            assert_eoi_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (eoi_hit && !(acc && acc_lvl && hit)) |=> !remote_irr[gi]);

            // R8: an EOI leaves edge pins alone when no acceptance targets them
            assert_eoi_edge_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (eoi_valid && !cfg_lvl[gi] && !(acc && hit)) |=> $stable(remote_irr[gi]));
        end
    endgenerate

    // R7: without an acceptance or EOI, remote IRR never moves
    assert_remote_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !eoi_valid) |=> $stable(remote_irr));

    // R1: without presentation or acceptance, delivery status never moves
    assert_dlv_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !set_pend) |=> $stable(dlv_status));

    // R9: a level acceptance always leaves remote IRR set
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_lvl) |=> remote_irr[$past(upd_pin)]);

    // R6: an acceptance always clears delivery status
    assert_acc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !dlv_status[$past(upd_pin)]);

endmodule

// File: rtl/dispatch_ctrl.sv
// Module: dispatch_ctrl
// Sequences one request: capture, table lookup, message offer, response.
// Assumes: the table answers in the same cycle as tbl_rd_idx (driven by
// pin_q); responses are only taken after the message handshake.
module dispatch_ctrl
    import irq_msi_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W = $clog2(NUM_PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_valid,
    input  logic [IDX_W-1:0] svc_pin,
    output logic             svc_busy,
    output logic [IDX_W-1:0] pin_q,
    input  logic             ent_masked,
    input  logic             ent_level,
    input  logic [MSG_W-1:0] cmp_addr,
    input  logic [MSG_W-1:0] cmp_data,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [MSG_W-1:0] msg_addr,
    output logic [MSG_W-1:0] msg_data,
    input  logic             rsp_valid,
    input  logic             rsp_accept,
    output logic             set_pend,
    output logic             acc,
    output logic             acc_lvl
);

    disp_state_t state;
    logic        in_range;

    assign in_range = int'(svc_pin) < NUM_PINS;

    // Request sequencing and message capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pin_q    <= '0;
            msg_addr <= '0;
            msg_data <= '0;
            acc_lvl  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (svc_valid && in_range) begin
                        pin_q <= svc_pin;
                        state <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (ent_masked) begin
                        state <= ST_IDLE;
                    end else begin
                        msg_addr <= cmp_addr;
                        msg_data <= cmp_data;
                        acc_lvl  <= ent_level;
                        state    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (msg_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_valid) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status strobes and channel outputs
    always_comb begin
        svc_busy  = (state != ST_IDLE);
        msg_valid = (state == ST_SEND);
        set_pend  = (state == ST_LOOKUP) && !ent_masked;
        acc       = (state == ST_WAIT) && rsp_valid && rsp_accept;
    end

    // R12: an offered message holds until taken
    assert_msg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R10: the serviced pin index does not change while busy
    assert_pin_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_busy && svc_valid) |=> $stable(pin_q));

endmodule

// File: rtl/irq_msi_dispatch.sv
// Module: irq_msi_dispatch (top)
// Services interrupt pins by reading their redirection entry, building
// an MSI address/data pair, offering it on a valid/ready channel and
// updating per-pin remote-IRR and delivery-status bits.
// Assumes: a combinational external table read port; flat per-pin vector
// and trigger inputs for end-of-interrupt matching.
module irq_msi_dispatch
    import irq_msi_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      svc_valid,
    input  logic [IDX_W-1:0]          svc_pin,
    output logic                      svc_busy,
    output logic [IDX_W-1:0]          tbl_rd_idx,
    input  logic [ENTRY_W-1:0]        tbl_rd_data,
    input  logic [NUM_PINS*VEC_W-1:0] cfg_vec_flat,
    input  logic [NUM_PINS-1:0]       cfg_lvl,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [MSG_W-1:0]          msg_addr,
    output logic [MSG_W-1:0]          msg_data,
    input  logic                      rsp_valid,
    input  logic                      rsp_accept,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vec,
    output logic [NUM_PINS-1:0]       remote_irr_o,
    output logic [NUM_PINS-1:0]       dlv_status_o
);

    logic [IDX_W-1:0] pin_q;
    logic [MSG_W-1:0] cmp_addr;
    logic [MSG_W-1:0] cmp_data;
    logic             ent_masked;
    logic             ent_level;
    logic             cur_remote;
    logic             set_pend;
    logic             acc;
    logic             acc_lvl;

    assign tbl_rd_idx = pin_q;
    assign cur_remote = remote_irr_o[pin_q];

    msi_compose u_compose (
        .entry      (tbl_rd_data),
        .remote_bit (cur_remote),
        .addr       (cmp_addr),
        .data       (cmp_data),
        .masked     (ent_masked),
        .level      (ent_level)
    );

    dispatch_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .svc_valid  (svc_valid),
        .svc_pin    (svc_pin),
        .svc_busy   (svc_busy),
        .pin_q      (pin_q),
        .ent_masked (ent_masked),
        .ent_level  (ent_level),
        .cmp_addr   (cmp_addr),
        .cmp_data   (cmp_data),
        .msg_valid  (msg_valid),
        .msg_ready  (msg_ready),
        .msg_addr   (msg_addr),
        .msg_data   (msg_data),
        .rsp_valid  (rsp_valid),
        .rsp_accept (rsp_accept),
        .set_pend   (set_pend),
        .acc        (acc),
        .acc_lvl    (acc_lvl)
    );

    pin_status_bank #(.NUM_PINS(NUM_PINS)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_pend     (set_pend),
        .acc          (acc),
        .acc_lvl      (acc_lvl),
        .upd_pin      (pin_q),
        .eoi_valid    (eoi_valid),
        .eoi_vec      (eoi_vec),
        .cfg_vec_flat (cfg_vec_flat),
        .cfg_lvl      (cfg_lvl),
        .remote_irr   (remote_irr_o),
        .dlv_status   (dlv_status_o)
    );

    // R2: physical-mode messages never carry upper destination bits
    assert_phys_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_addr[2]) |-> (msg_addr[19:16] == 4'h0));

    // R13: the pin being offered is marked pending
    assert_pending_R13: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> dlv_status_o[tbl_rd_idx]);

    // R11: an out-of-range request from idle never starts a service
    assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_busy && svc_valid && (int'(svc_pin) >= NUM_PINS)) |=> !svc_busy);

endmodule

// File: tb/irq_msi_dispatch_test.sv
module irq_msi_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic svc_valid = 1'b0;
    logic [4:0] svc_pin = '0;
    logic svc_busy;
    logic [4:0] tbl_rd_idx;
    logic [63:0] tbl_rd_data;
    logic [NP*8-1:0] cfg_vec_flat;
    logic [NP-1:0] cfg_lvl;
    logic msg_valid;
    logic msg_ready = 1'b0;
    logic [31:0] msg_addr, msg_data;
    logic rsp_valid = 1'b0, rsp_accept = 1'b0;
    logic eoi_valid = 1'b0;
    logic [7:0] eoi_vec = '0;
    logic [NP-1:0] remote_irr_o, dlv_status_o;

    logic [63:0] tbl [NP];
    int nvec = 0;
    int nbad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tbl_rd_data = (int'(tbl_rd_idx) < NP) ? tbl[tbl_rd_idx] : 64'h0;
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            cfg_vec_flat[i*8 +: 8] = tbl[i][7:0];
            cfg_lvl[i] = tbl[i][15];
        end
    end

    irq_msi_dispatch uut (
        .clk(clk), .rst_n(rst_n), .svc_valid(svc_valid), .svc_pin(svc_pin),
        .svc_busy(svc_busy), .tbl_rd_idx(tbl_rd_idx), .tbl_rd_data(tbl_rd_data),
        .cfg_vec_flat(cfg_vec_flat), .cfg_lvl(cfg_lvl), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .eoi_valid(eoi_valid),
        .eoi_vec(eoi_vec), .remote_irr_o(remote_irr_o), .dlv_status_o(dlv_status_o)
    );

    function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm,
                                       input logic logical, input logic lvl,
                                       input logic mask, input logic [7:0] dest);
        return {dest, 39'b0, mask, lvl, 3'b000, logical, dm, vec};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [63:0] e);
        logic [7:0] d;
        d = e[11] ? e[63:56] : {4'h0, e[59:56]};
        return 32'hFEE0_0000 | ({24'h0, d} << 12) | 32'h8 | ({31'h0, e[11]} << 2);
    endfunction

    function automatic logic [31:0] exp_data(input logic [63:0] e, input logic rirr);
        return ({31'h0, e[15]} << 15) | ({31'h0, rirr} << 14) |
               ({29'h0, e[10:8]} << 8) | {24'h0, e[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request; returns at the negedge after capture
    task automatic issue(input logic [4:0] pin);
        @(negedge clk);
        svc_valid = 1'b1;
        svc_pin = pin;
        @(negedge clk);
        svc_valid = 1'b0;
    endtask

    task automatic wait_msg(output bit got);
        got = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (msg_valid) begin got = 1; break; end
        end
    endtask

    // Take the offered message and respond; returns with the update visible
    task automatic respond(input bit accept, input bit with_eoi, input logic [7:0] ev);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        rsp_valid = 1'b1;
        rsp_accept = accept;
        eoi_valid = with_eoi;
        eoi_vec = ev;
        @(negedge clk);
        rsp_valid = 1'b0;
        eoi_valid = 1'b0;
    endtask

    task automatic serve(input logic [4:0] pin, input bit accept, input string req,
                         input logic exp_rirr);
        bit got;
        issue(pin);
        wait_msg(got);
        chk(got, req, {63'h0, got}, 64'h1);
        chk(msg_addr == exp_addr(tbl[pin]), req, {32'h0, msg_addr}, {32'h0, exp_addr(tbl[pin])});
        chk(msg_data == exp_data(tbl[pin], exp_rirr), req, {32'h0, msg_data},
            {32'h0, exp_data(tbl[pin], exp_rirr)});
        respond(accept, 1'b0, 8'h0);
    endtask

    task automatic t_reset();
        chk(msg_valid == 0 && svc_busy == 0, "R13 reset outputs", {62'h0, msg_valid, svc_busy}, 64'h0);
        chk(remote_irr_o == 0 && dlv_status_o == 0, "R13 reset status",
            {16'h0, remote_irr_o, dlv_status_o}, 64'h0);
    endtask

    task automatic t_edge_physical();
        tbl[1] = mk(8'h30, 3'd0, 1'b0, 1'b0, 1'b0, 8'hA5);
        serve(5'd1, 1'b1, "R2 R3 R4 edge physical", 1'b0);
        chk(msg_addr == 32'hFEE0_5008, "R2 physical dest nibble", {32'h0, msg_addr}, 64'hFEE0_5008);
        chk(dlv_status_o[1] == 0 && remote_irr_o[1] == 0, "R6 edge accept",
            {62'h0, dlv_status_o[1], remote_irr_o[1]}, 64'h0);
    endtask

    task automatic t_level_logical();
        tbl[3] = mk(8'h41, 3'd1, 1'b1, 1'b1, 1'b0, 8'hC3);
        serve(5'd3, 1'b1, "R3 R4 level logical first", 1'b0);
        chk(msg_addr == 32'hFEEC_300C, "R3 logical address", {32'h0, msg_addr}, 64'hFEEC_300C);
        chk(remote_irr_o[3] == 1 && dlv_status_o[3] == 0, "R6 level accept",
            {62'h0, remote_irr_o[3], dlv_status_o[3]}, 64'h2);
        serve(5'd3, 1'b1, "R4 second delivery pre-update remote", 1'b1);
        chk(msg_data == 32'h0000_C141, "R4 data with remote", {32'h0, msg_data}, 64'hC141);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 8; m++) begin
            tbl[5] = mk(8'h10 + 8'(m), 3'(m), 1'b0, 1'b0, 1'b0, 8'h02);
            serve(5'd5, 1'b1, "R5 delivery mode pass-through", 1'b0);
            chk(msg_data[10:8] == 3'(m), "R5 mode field", {61'h0, msg_data[10:8]}, 64'(m));
        end
    endtask

    task automatic t_reject_and_hold();
        bit got;
        logic [31:0] a0, d0;
        tbl[7] = mk(8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 8'h07);
        serve(5'd7, 1'b0, "R7 reject message", 1'b0);
        chk(dlv_status_o[7] == 1 && remote_irr_o[7] == 0, "R7 reject keeps status",
            {62'h0, dlv_status_o[7], remote_irr_o[7]}, 64'h2);
        issue(5'd7);
        wait_msg(got);
        a0 = msg_addr;
        d0 = msg_data;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(msg_valid && msg_addr == a0 && msg_data == d0, "R12 hold under back-pressure",
                {msg_addr, msg_data}, {a0, d0});
        end
        respond(1'b1, 1'b0, 8'h0);
        chk(remote_irr_o[7] == 1 && dlv_status_o[7] == 0, "R6 accept after reject",
            {62'h0, remote_irr_o[7], dlv_status_o[7]}, 64'h2);
    endtask

    task automatic t_masked();
        logic [NP-1:0] r0, s0;
        bit seen = 0;
        tbl[3][16] = 1'b1;
        r0 = remote_irr_o;
        s0 = dlv_status_o;
        issue(5'd3);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        chk(!seen, "R1 masked no message", {63'h0, seen}, 64'h0);
        chk(!svc_busy, "R10 busy released after drop", {63'h0, svc_busy}, 64'h0);
        chk(remote_irr_o == r0 && dlv_status_o == s0, "R1 masked status unchanged",
            {16'h0, remote_irr_o, dlv_status_o}, {16'h0, r0, s0});
        tbl[3][16] = 1'b0;
    endtask

    task automatic t_eoi();
        tbl[10] = mk(8'h41, 3'd0, 1'b0, 1'b1, 1'b0, 8'h01);
        tbl[11] = mk(8'h41, 3'd0, 1'b0, 1'b1, 1'b0, 8'h01);
        tbl[12] = mk(8'h42, 3'd0, 1'b0, 1'b1, 1'b0, 8'h01);
        serve(5'd10, 1'b1, "R8 setup pin10", 1'b0);
        serve(5'd11, 1'b1, "R8 setup pin11", 1'b0);
        serve(5'd12, 1'b1, "R8 setup pin12", 1'b0);
        tbl[11][15] = 1'b0;
        @(negedge clk);
        eoi_valid = 1'b1;
        eoi_vec = 8'h41;
        @(negedge clk);
        eoi_valid = 1'b0;
        chk(remote_irr_o[3] == 0 && remote_irr_o[10] == 0, "R8 matching level cleared",
            {62'h0, remote_irr_o[3], remote_irr_o[10]}, 64'h0);
        chk(remote_irr_o[11] == 1, "R8 edge pin unaffected", {63'h0, remote_irr_o[11]}, 64'h1);
        chk(remote_irr_o[12] == 1 && remote_irr_o[7] == 1, "R8 other vectors kept",
            {62'h0, remote_irr_o[12], remote_irr_o[7]}, 64'h3);
    endtask

    task automatic t_set_wins();
        bit got;
        tbl[13] = mk(8'h50, 3'd0, 1'b0, 1'b1, 1'b0, 8'h01);
        tbl[14] = mk(8'h50, 3'd0, 1'b0, 1'b1, 1'b0, 8'h01);
        serve(5'd14, 1'b1, "R9 setup pin14", 1'b0);
        issue(5'd13);
        wait_msg(got);
        respond(1'b1, 1'b1, 8'h50);
        chk(remote_irr_o[13] == 1, "R9 set wins over EOI", {63'h0, remote_irr_o[13]}, 64'h1);
        chk(remote_irr_o[14] == 0, "R8 same-cycle EOI clears other pin",
            {63'h0, remote_irr_o[14]}, 64'h0);
    endtask

    task automatic t_busy();
        bit got;
        bit seen = 0;
        tbl[4] = mk(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 8'h01);
        tbl[6] = mk(8'h23, 3'd0, 1'b0, 1'b1, 1'b0, 8'h01);
        @(negedge clk);
        svc_valid = 1'b1;
        svc_pin = 5'd4;
        @(negedge clk);
        svc_pin = 5'd6;
        chk(svc_busy == 1, "R10 busy after capture", {63'h0, svc_busy}, 64'h1);
        wait_msg(got);
        chk(msg_data[7:0] == 8'h22, "R10 first request served", {56'h0, msg_data[7:0]}, 64'h22);
        svc_valid = 1'b0;
        respond(1'b1, 1'b0, 8'h0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (msg_valid || svc_busy) seen = 1;
        end
        chk(!seen && dlv_status_o[6] == 0 && remote_irr_o[6] == 0, "R10 busy request ignored",
            {61'h0, seen, dlv_status_o[6], remote_irr_o[6]}, 64'h0);
    endtask

    task automatic t_range();
        bit seen = 0;
        @(negedge clk);
        svc_valid = 1'b1;
        svc_pin = 5'd24;
        @(negedge clk);
        if (svc_busy) seen = 1;
        svc_pin = 5'd31;
        @(negedge clk);
        if (svc_busy) seen = 1;
        svc_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (svc_busy || msg_valid) seen = 1;
        end
        chk(!seen, "R11 out-of-range ignored", {63'h0, seen}, 64'h0);
    endtask

    initial begin
        for (int i = 0; i < NP; i++) tbl[i] = 64'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge_physical();
        t_level_logical();
        t_modes();
        t_reject_and_hold();
        t_masked();
        t_eoi();
        t_set_wins();
        t_busy();
        t_range();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nvec++;
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule